// File: doc/BRIEF.md
# UART Prioritized Interrupt Identifier

This block sits beside the receive and transmit datapaths of a 16550-style UART. It collects six interrupt conditions and reduces them to one 4-bit identification code that software reads to find the most urgent pending cause. It also drives one interrupt request line. The six conditions are:

- a receive line error
- receive data at or above the FIFO trigger level
- a receive character timeout
- an empty transmit holding register
- a modem-line change
- a catch-all group of extra ("multi-mode") flags

The FIFOs, the baud generator and the shifters stay outside the block, which sees only their status levels and access strobes. Three conditions are held in sticky flags inside the block: the timeout, the transmit-empty event and the modem change. Each flag has its own clearing access. The other three conditions follow their input levels. The character timeout is measured here by counting character-time ticks.

Each condition passes through an enable bit before prioritization. A disabled condition keeps its flag and reappears as soon as it is enabled again. The code and the request line are registered.

Top module: `uart_irq_ident`

## Requirements
- R1: After a synchronous reset, `iir_o` is 0001 and `irq_o` is low.
- R2: While `line_err_i` is high and its enable is set, `iir_o` is 0110, whatever else is pending.
- R3: While `rx_trig_i` is high and the receive enable is set, `iir_o` is 0100 unless a line error outranks it. The code goes away once `rx_trig_i` drops.
- R4: Four character ticks (`TO_CHARS`) counted while `rx_nempty_i` is high and no `rbr_rd_i` occurs raise a timeout. The timeout gives code 1100 and is cleared by `rbr_rd_i`. Ticks seen while the FIFO is empty do not count. When receive data and a timeout are both pending, 0100 is shown.
- R5: A rising edge of `thr_empty_i` raises the transmit-empty flag, which gives code 0010. A `thr_wr_i` strobe clears it.
- R6: An `iir_rd_i` strobe clears the transmit-empty flag only when `iir_o` shows 0010 during that read. A read that shows another code leaves the flag pending.
- R7: A pulse on any bit of `modem_delta_i` raises a sticky modem flag, which gives code 0000. An `msr_rd_i` strobe clears it.
- R8: While any bit of `mm_flags_i` is high and its enable is set, the multi-mode code 0011 is shown when nothing of higher priority is pending.
- R9: Enable bits in `ier_i` are: bit 0 for receive data and timeout, bit 1 for transmit empty, bit 2 for line error, bit 3 for modem change, bit 4 for multi-mode. A cleared enable hides its source from the code and the request line but does not clear the source's flag.
- R10: `irq_o` is high exactly when `iir_o` differs from 0001.
- R11: Priority from highest to lowest is line error, receive data / timeout, transmit empty, modem change, multi-mode. With nothing enabled and pending, the code is 0001.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| ier_i | input | 5 | Per-source enable bits |
| line_err_i | input | 1 | Receive line error pending (level) |
| rx_trig_i | input | 1 | Receive FIFO at or above trigger level |
| rx_nempty_i | input | 1 | Receive FIFO holds at least one character |
| char_tick_i | input | 1 | One-cycle pulse per character time |
| rbr_rd_i | input | 1 | Receive buffer read strobe |
| thr_empty_i | input | 1 | Transmit holding register empty (level) |
| thr_wr_i | input | 1 | Transmit holding register write strobe |
| iir_rd_i | input | 1 | Identification register read strobe |
| modem_delta_i | input | 4 | Modem line change pulses |
| msr_rd_i | input | 1 | Modem status read strobe |
| mm_flags_i | input | MM_W | Multi-mode interrupt flags (level) |
| iir_o | output | 4 | Registered identification code |
| irq_o | output | 1 | Registered interrupt request |

## Verification
The bench sweeps every enable pattern against every combination of the level sources, with all sticky flags pending. A priority or enable-mapping slip would therefore show a wrong code for some pattern.

The timeout is probed one tick short of its threshold and with ticks that arrive while the FIFO is empty. An off-by-one counter would raise 1100 early, and a counter that ignores FIFO occupancy would raise it spuriously.

The transmit-empty flag is read while a line error masks it. A design that clears it on any identification read would lose the interrupt and show 0001 where 0010 is expected.

A disabled modem change is brought back by re-enabling it. A design that clears flags under a zero enable would stay silent.

// File: rtl/uart_irq_pkg.sv
package uart_irq_pkg;

  typedef enum logic [3:0] {
    ID_MSI  = 4'b0000,
    ID_NONE = 4'b0001,
    ID_THRE = 4'b0010,
    ID_MM   = 4'b0011,
    ID_RDA  = 4'b0100,
    ID_RLS  = 4'b0110,
    ID_TO   = 4'b1100
  } irq_id_e;

  localparam int EN_RX = 0;
  localparam int EN_TX = 1;
  localparam int EN_LS = 2;
  localparam int EN_MS = 3;
  localparam int EN_MM = 4;
  localparam int EN_W  = 5;

  typedef struct packed {
    logic ls;
    logic rda;
    logic to;
    logic thre;
    logic ms;
    logic mm;
  } irq_src_t;

endpackage

// File: rtl/uart_irq_timeout.sv
module uart_irq_timeout #(
  parameter int TO_CHARS = 4
) (
  input  logic clk,
  input  logic rst,
  input  logic rx_nempty,
  input  logic char_tick,
  input  logic rbr_rd,
  output logic to_pend
);
  localparam int CNT_W = $clog2(TO_CHARS + 1);
  localparam logic [CNT_W-1:0] LIMIT   = CNT_W'(TO_CHARS);
  localparam logic [CNT_W-1:0] LAST_CT = CNT_W'(TO_CHARS - 1);

  logic [CNT_W-1:0] cnt;

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt     <= '0;
      to_pend <= 1'b0;
    end else begin
      if (rbr_rd || !rx_nempty)
        cnt <= '0;
      else if (char_tick && cnt != LIMIT)
        cnt <= cnt + 1'b1;

      if (rbr_rd)
        to_pend <= 1'b0;
      else if (rx_nempty && char_tick && cnt == LAST_CT)
        to_pend <= 1'b1;
    end
  end
endmodule

// File: rtl/uart_irq_flag.sv
module uart_irq_flag #(
  parameter bit SET_WINS = 1'b1
) (
  input  logic clk,
  input  logic rst,
  input  logic set,
  input  logic clr,
  output logic q
);
  generate
    if (SET_WINS) begin : g_set_first
      always_ff @(posedge clk) begin
        if (rst)      q <= 1'b0;
        else if (set) q <= 1'b1;
        else if (clr) q <= 1'b0;
      end
    end else begin : g_clr_first
      always_ff @(posedge clk) begin
        if (rst)      q <= 1'b0;
        else if (clr) q <= 1'b0;
        else if (set) q <= 1'b1;
      end
    end
  endgenerate
endmodule

// File: rtl/uart_irq_prio.sv
module uart_irq_prio
  import uart_irq_pkg::*;
(
  input  irq_src_t           src,
  input  logic [EN_W-1:0]    ier,
  output irq_id_e            code
);
  irq_src_t g;

  always_comb begin
    g.ls   = src.ls   & ier[EN_LS];
    g.rda  = src.rda  & ier[EN_RX];
    g.to   = src.to   & ier[EN_RX];
    g.thre = src.thre & ier[EN_TX];
    g.ms   = src.ms   & ier[EN_MS];
    g.mm   = src.mm   & ier[EN_MM];

    if (g.ls)        code = ID_RLS;
    else if (g.rda)  code = ID_RDA;
    else if (g.to)   code = ID_TO;
    else if (g.thre) code = ID_THRE;
    else if (g.ms)   code = ID_MSI;
    else if (g.mm)   code = ID_MM;
    else             code = ID_NONE;
  end
endmodule

// File: rtl/uart_irq_ident.sv
module uart_irq_ident
  import uart_irq_pkg::*;
#(
  parameter int MM_W     = 5,
  parameter int TO_CHARS = 4
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [4:0]       ier_i,
  input  logic             line_err_i,
  input  logic             rx_trig_i,
  input  logic             rx_nempty_i,
  input  logic             char_tick_i,
  input  logic             rbr_rd_i,
  input  logic             thr_empty_i,
  input  logic             thr_wr_i,
  input  logic             iir_rd_i,
  input  logic [3:0]       modem_delta_i,
  input  logic             msr_rd_i,
  input  logic [MM_W-1:0]  mm_flags_i,
  output logic [3:0]       iir_o,
  output logic             irq_o
);
  logic     thr_empty_q;
  logic     thre_q;
  logic     ms_q;
  logic     to_pend;
  irq_src_t src;
  irq_id_e  code;

  always_ff @(posedge clk) begin
    if (rst) thr_empty_q <= 1'b0;
    else     thr_empty_q <= thr_empty_i;
  end

  uart_irq_timeout #(.TO_CHARS(TO_CHARS)) u_timeout (
    .clk       (clk),
    .rst       (rst),
    .rx_nempty (rx_nempty_i),
    .char_tick (char_tick_i),
    .rbr_rd    (rbr_rd_i),
    .to_pend   (to_pend)
  );

  uart_irq_flag #(.SET_WINS(1'b0)) u_thre (
    .clk (clk),
    .rst (rst),
    .set (thr_empty_i && !thr_empty_q),
    .clr (thr_wr_i || (iir_rd_i && iir_o == ID_THRE)),
    .q   (thre_q)
  );

  uart_irq_flag #(.SET_WINS(1'b1)) u_modem (
    .clk (clk),
    .rst (rst),
    .set (|modem_delta_i),
    .clr (msr_rd_i),
    .q   (ms_q)
  );

  always_comb begin
    src.ls   = line_err_i;
    src.rda  = rx_trig_i;
    src.to   = to_pend;
    src.thre = thre_q;
    src.ms   = ms_q;
    src.mm   = |mm_flags_i;
  end

  uart_irq_prio u_prio (
    .src  (src),
    .ier  (ier_i),
    .code (code)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      iir_o <= ID_NONE;
      irq_o <= 1'b0;
    end else begin
      iir_o <= code;
      irq_o <= (code != ID_NONE);
    end
  end
endmodule

// File: rtl/uart_irq_ident_chk.sv
module uart_irq_ident_chk (
  input logic       clk,
  input logic       rst,
  input logic [4:0] ier_i,
  input logic       line_err_i,
  input logic       rbr_rd_i,
  input logic       thr_wr_i,
  input logic [3:0] modem_delta_i,
  input logic [3:0] iir_o,
  input logic       irq_o,
  input logic       to_pend,
  input logic       thre_q,
  input logic       ms_q
);
  p_irq_code_r10: assert property (@(posedge clk) disable iff (rst)
    irq_o == (iir_o != 4'b0001));

  p_rls_first_r2: assert property (@(posedge clk) disable iff (rst)
    (line_err_i && ier_i[2]) |=> iir_o == 4'b0110);

  p_to_clear_r4: assert property (@(posedge clk) disable iff (rst)
    rbr_rd_i |=> !to_pend);

  p_thre_wr_r5: assert property (@(posedge clk) disable iff (rst)
    thr_wr_i |=> !thre_q);

  p_msi_set_r7: assert property (@(posedge clk) disable iff (rst)
    (|modem_delta_i) |=> ms_q);

  p_off_quiet_r9: assert property (@(posedge clk) disable iff (rst)
    (ier_i == 5'd0) |=> !irq_o);

  p_legal_code_r11: assert property (@(posedge clk) disable iff (rst)
    iir_o inside {4'b0000, 4'b0001, 4'b0010, 4'b0011,
                  4'b0100, 4'b0110, 4'b1100});
endmodule

bind uart_irq_ident uart_irq_ident_chk u_chk (
  .clk           (clk),
  .rst           (rst),
  .ier_i         (ier_i),
  .line_err_i    (line_err_i),
  .rbr_rd_i      (rbr_rd_i),
  .thr_wr_i      (thr_wr_i),
  .modem_delta_i (modem_delta_i),
  .iir_o         (iir_o),
  .irq_o         (irq_o),
  .to_pend       (to_pend),
  .thre_q        (thre_q),
  .ms_q          (ms_q)
);

// File: tb/uart_irq_ident_test.sv
`timescale 1ns/1ps
module uart_irq_ident_test;
  localparam int MM_W = 5;

  logic            clk = 1'b0;
  logic            rst;
  logic [4:0]      ier;
  logic            line_err, rx_trig, rx_ne, tick, rbr_rd;
  logic            thr_empty, thr_wr, iir_rd, msr_rd;
  logic [3:0]      delta;
  logic [MM_W-1:0] mm;
  logic [3:0]      iir;
  logic            irq;

  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;

  always #2.5 clk = ~clk;

  uart_irq_ident #(.MM_W(MM_W), .TO_CHARS(4)) uut (
    .clk(clk), .rst(rst), .ier_i(ier), .line_err_i(line_err),
    .rx_trig_i(rx_trig), .rx_nempty_i(rx_ne), .char_tick_i(tick),
    .rbr_rd_i(rbr_rd), .thr_empty_i(thr_empty), .thr_wr_i(thr_wr),
    .iir_rd_i(iir_rd), .modem_delta_i(delta), .msr_rd_i(msr_rd),
    .mm_flags_i(mm), .iir_o(iir), .irq_o(irq)
  );

  function automatic logic [3:0] exp_code(input logic [4:0] en,
      input logic ls, rda, to, thre, ms, mmf);
    if (ls && en[2])        return 4'b0110;
    else if (rda && en[0])  return 4'b0100;
    else if (to && en[0])   return 4'b1100;
    else if (thre && en[1]) return 4'b0010;
    else if (ms && en[3])   return 4'b0000;
    else if (mmf && en[4])  return 4'b0011;
    return 4'b0001;
  endfunction

  task automatic chk(input string req, input logic [3:0] act, input logic [3:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual=%b expected=%b", req, act, exp);
    end
  endtask

  task automatic settle();
    repeat (3) @(posedge clk);
    @(negedge clk);
  endtask

  task automatic chk_code(input string req, input logic [3:0] exp);
    settle();
    chk(req, iir, exp);
    chk("R10", {3'b0, irq}, {3'b0, exp != 4'b0001});
  endtask

  task automatic do_tick();    tick = 1;   @(negedge clk); tick = 0;   endtask
  task automatic do_rbr();     rbr_rd = 1; @(negedge clk); rbr_rd = 0; endtask
  task automatic do_thr_wr();  thr_wr = 1; @(negedge clk); thr_wr = 0; endtask
  task automatic do_iir_rd();  iir_rd = 1; @(negedge clk); iir_rd = 0; endtask
  task automatic do_msr_rd();  msr_rd = 1; @(negedge clk); msr_rd = 0; endtask
  task automatic do_delta(input logic [3:0] d); delta = d; @(negedge clk); delta = 0; endtask

  initial begin
    rst = 1; ier = 0; line_err = 0; rx_trig = 0; rx_ne = 0; tick = 0;
    rbr_rd = 0; thr_empty = 0; thr_wr = 0; iir_rd = 0; msr_rd = 0;
    delta = 0; mm = 0;
    repeat (4) @(posedge clk);
    @(negedge clk);
    chk("R1", iir, 4'b0001);
    chk("R1", {3'b0, irq}, 4'b0000);
    rst = 0;

    // R4: timeout threshold, empty-FIFO ticks, RDA wins, read clears
    ier = 5'b00001;
    repeat (5) do_tick();
    chk_code("R4 empty ticks", 4'b0001);
    rx_ne = 1;
    repeat (3) do_tick();
    chk_code("R4 three ticks", 4'b0001);
    do_tick();
    chk_code("R4 fourth tick", 4'b1100);
    rx_trig = 1;
    chk_code("R4 rda over timeout", 4'b0100);
    rx_trig = 0;
    chk_code("R4 timeout back", 4'b1100);
    do_rbr();
    chk_code("R4 read clears", 4'b0001);

    // set all sticky flags, then sweep enables and level sources (R11, R9, R2, R3, R8)
    repeat (4) do_tick();
    thr_empty = 1;
    do_delta(4'b0001);
    for (int e = 0; e < 32; e++) begin
      for (int l = 0; l < 8; l++) begin
        ier = e[4:0]; line_err = l[0]; rx_trig = l[1]; mm = {4'b0, l[2]};
        chk_code("R11 sweep", exp_code(e[4:0], l[0], l[1], 1'b1, 1'b1, 1'b1, l[2]));
      end
    end
    line_err = 0; rx_trig = 0; mm = 0;

    // R5: write clears, new rising edge re-raises
    ier = 5'b00010;
    chk_code("R5 pending", 4'b0010);
    do_thr_wr();
    chk_code("R5 write clears", 4'b0001);
    thr_empty = 0;
    settle();
    thr_empty = 1;
    chk_code("R5 re-raise", 4'b0010);

    // R6: identification read clears only when 0010 was shown
    do_rbr();
    do_msr_rd();
    ier = 5'b00110;
    line_err = 1;
    chk_code("R6 masked by rls", 4'b0110);
    do_iir_rd();
    line_err = 0;
    chk_code("R6 survives other read", 4'b0010);
    do_iir_rd();
    chk_code("R6 read clears", 4'b0001);

    // R7: each modem delta bit
    ier = 5'b01000;
    for (int b = 0; b < 4; b++) begin
      do_delta(4'(1 << b));
      chk_code("R7 delta", 4'b0000);
      do_msr_rd();
      chk_code("R7 msr read clears", 4'b0001);
    end

    // R8: each multi-mode bit
    ier = 5'b10000;
    for (int b = 0; b < MM_W; b++) begin
      mm = MM_W'(1 << b);
      chk_code("R8 mm bit", 4'b0011);
    end
    mm = 0;
    chk_code("R8 mm idle", 4'b0001);

    // R9: disabled source is hidden but retained
    ier = 5'b00000;
    do_delta(4'b0100);
    chk_code("R9 hidden", 4'b0001);
    ier = 5'b01000;
    chk_code("R9 retained", 4'b0000);
    do_msr_rd();

    // R3: level-following receive data
    ier = 5'b00001;
    rx_trig = 1;
    chk_code("R3 at trigger", 4'b0100);
    rx_trig = 0;
    chk_code("R3 below trigger", 4'b0001);

    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      checks++;
      fails++;
      $display("FAIL watchdog: actual=timeout expected=completion");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end
endmodule